// File: doc/BRIEF.md
# Ternary-Match Trigger Item Combiner

This block turns a vector of synchronized input bits into a vector of trigger items once per bunch-crossing clock. The inputs are a set of external bits joined with a few internally generated bits: a random trigger, a prescaled clock and bunch-crossing group flags. Small lookup tables, one per condition bit, each read a fixed group of input bits and produce one condition bit. Every trigger item then compares the whole condition vector against its own programmed ternary word. The word holds a value and a care mask, so each condition position can demand 0, demand 1 or be skipped.

The tables and the ternary words are loaded through a single-cycle write port. A value or care word is first written into a shared staging register. A separate commit write then copies both halves into one item in the same clock edge, so no item ever matches against a half-loaded word. Full-size use is 160 external plus 12 internal inputs, 256 conditions and 256 items. The default parameters are reduced for simulation.

Top module: `trig_item_combiner`

## Requirements
- R1: While `rst_n` is low and after its release, all items are 0, all lookup tables hold 0 and every care mask is 0, until something is programmed.
- R2: The combined input is `{int_in, ext_in}` (external bits in the low positions). Condition c takes its table address from bits `[g*LUT_IN +: LUT_IN]` of the combined input, where g = c mod (N_EXT+N_INT)/LUT_IN. The condition value is bit `addr` of table c.
- R3: Item i is 1 exactly when its care mask is nonzero and every condition bit whose care bit is 1 equals the matching value bit.
- R4: An item whose care mask is all zero stays 0 whatever the inputs are.
- R5: Items are registered. Inputs sampled at rising edge k show up on `items` after rising edge k+1, and a new input vector may be applied every cycle.
- R6: A write with `wr_sel` = 1 (value) or 2 (care) changes only the staging register. No item's behaviour changes until a commit.
- R7: A write with `wr_sel` = 3 (commit) copies the staged value and care into item `wr_idx` in one edge, and leaves every other item unchanged. A write with `wr_sel` = 0 loads `wr_data[2**LUT_IN-1:0]` into table `wr_idx`.
- R8: A write with `wr_en` low, or a commit whose `wr_idx` is not below N_ITEM, changes nothing.
- R9: Value bits at positions whose care bit is 0 have no effect on the item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | N_EXT | Synchronized external input bits |
| int_in | input | N_INT | Internally generated input bits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 table, 1 staged value, 2 staged care, 3 commit |
| wr_idx | input | IDX_W | Table index or item index |
| wr_data | input | DATA_W | Write data |
| items | output | N_ITEM | Registered trigger items |

## Verification
On every cycle, the assertions check the following. An all-zero care mask forces its item low one edge later. A cared-for mismatch forces the item low. Staging writes leave every committed word untouched. A commit loads exactly its target item with the staged pair and leaves all other items unchanged. Only the bench's scenarios can show three further behaviours: the lookup-table addressing of conditions, the two-stage pipelining of back-to-back random input vectors, and the fact that disabled or out-of-range writes leave the outputs as they were. The bench compares `items` against its own model of tables and ternary words.

// File: rtl/trig_comb_pkg.sv
// Shared definitions for the trigger item combiner.
// Assumes: the write selector is two bits wide.
package trig_comb_pkg;
    typedef enum logic [1:0] {
        SEL_LUT    = 2'd0,
        SEL_VAL    = 2'd1,
        SEL_CARE   = 2'd2,
        SEL_COMMIT = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/tc_lut_bank.sv
// Bank of per-condition lookup tables with a registered condition vector.
// Each table reads a fixed group of LUT_IN input bits; condition c uses
// group (c mod number of groups). Assumes N_IN is a multiple of LUT_IN.
module tc_lut_bank
    import trig_comb_pkg::*;
#(
    parameter int N_IN   = 24,
    parameter int N_COND = 16,
    parameter int LUT_IN = 4,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_vec,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_COND-1:0] cond_q
);
    localparam int DEPTH = 1 << LUT_IN;
    localparam int N_GRP = N_IN / LUT_IN;

    for (genvar c = 0; c < N_COND; c++) begin : g_cond
        localparam int GRP = c % N_GRP;
        logic [DEPTH-1:0]  table_q;
        logic [LUT_IN-1:0] addr;

        assign addr = in_vec[GRP*LUT_IN +: LUT_IN];

        // Load table contents from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                table_q <= '0;
            end else if (wr_en && wr_sel == SEL_LUT && wr_idx == IDX_W'(c)) begin
                table_q <= wr_data[DEPTH-1:0];
            end
        end

        // Register the looked-up condition bit (first pipeline stage).
        always_ff @(posedge clk) begin
            if (!rst_n) cond_q[c] <= 1'b0;
            else        cond_q[c] <= table_q[addr];
        end
    end
endmodule

// File: rtl/tc_cfg_stage.sv
// Staging register for one ternary word plus commit decode.
// Value and care are written separately, then a commit strobes one item.
// Assumes commit indices at or above N_ITEM are to be ignored.
module tc_cfg_stage
    import trig_comb_pkg::*;
#(
    parameter int N_COND = 16,
    parameter int N_ITEM = 8,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_COND-1:0] stage_val,
    output logic [N_COND-1:0] stage_care,
    output logic [N_ITEM-1:0] commit_en
);
    // Capture staged value and care halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_val  <= '0;
            stage_care <= '0;
        end else if (wr_en && wr_sel == SEL_VAL) begin
            stage_val  <= wr_data[N_COND-1:0];
        end else if (wr_en && wr_sel == SEL_CARE) begin
            stage_care <= wr_data[N_COND-1:0];
        end
    end

    // Decode the commit strobe for each item.
    for (genvar i = 0; i < N_ITEM; i++) begin : g_dec
        assign commit_en[i] = wr_en && (wr_sel == SEL_COMMIT) && (wr_idx == IDX_W'(i));
    end
endmodule

// File: rtl/tc_item.sv
// One trigger item: holds a committed ternary word and registers its match.
// Assumes cond_q is already registered; an empty care mask never matches.
module tc_item #(
    parameter int N_COND = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [N_COND-1:0] stage_val,
    input  logic [N_COND-1:0] stage_care,
    input  logic [N_COND-1:0] cond_q,
    output logic [N_COND-1:0] val_q,
    output logic [N_COND-1:0] care_q,
    output logic              hit_q
);
    logic [N_COND-1:0] miss;
    assign miss = (cond_q ^ val_q) & care_q;

    // Load both halves of the word together on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            care_q <= '0;
        end else if (commit) begin
            val_q  <= stage_val;
            care_q <= stage_care;
        end
    end

    // Register the ternary match result (second pipeline stage).
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= (|care_q) && (miss == '0);
    end
endmodule

// File: rtl/trig_item_combiner.sv
// Top: lookup-table conditions followed by per-item ternary matching.
// Latency from input sample to item output is two register stages.
// Assumes (N_EXT+N_INT) is a multiple of LUT_IN and DATA_W covers both
// a table and a ternary word.
module trig_item_combiner
    import trig_comb_pkg::*;
#(
    parameter int N_EXT  = 20,
    parameter int N_INT  = 4,
    parameter int N_COND = 16,
    parameter int N_ITEM = 8,
    parameter int LUT_IN = 4,
    parameter int IDX_W  = $clog2((N_COND > N_ITEM) ? N_COND : N_ITEM),
    parameter int DATA_W = (N_COND > (1 << LUT_IN)) ? N_COND : (1 << LUT_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_in,
    input  logic [N_INT-1:0]  int_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_ITEM-1:0] items
);
    localparam int N_IN = N_EXT + N_INT;

    logic [N_IN-1:0]                in_vec;
    logic [N_COND-1:0]              cond_q;
    logic [N_COND-1:0]              stage_val;
    logic [N_COND-1:0]              stage_care;
    logic [N_ITEM-1:0]              commit_en;
    logic [N_ITEM-1:0][N_COND-1:0]  val_all;
    logic [N_ITEM-1:0][N_COND-1:0]  care_all;

    assign in_vec = {int_in, ext_in};

    tc_lut_bank #(
        .N_IN(N_IN), .N_COND(N_COND), .LUT_IN(LUT_IN),
        .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_luts (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .cond_q(cond_q)
    );

    tc_cfg_stage #(
        .N_COND(N_COND), .N_ITEM(N_ITEM), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .stage_val(stage_val), .stage_care(stage_care), .commit_en(commit_en)
    );

    for (genvar i = 0; i < N_ITEM; i++) begin : g_item
        tc_item #(.N_COND(N_COND)) u_item (
            .clk(clk), .rst_n(rst_n), .commit(commit_en[i]),
            .stage_val(stage_val), .stage_care(stage_care), .cond_q(cond_q),
            .val_q(val_all[i]), .care_q(care_all[i]), .hit_q(items[i])
        );
    end
endmodule

// File: rtl/trig_item_combiner_chk.sv
// Assertion checker for trig_item_combiner, attached by bind below.
module trig_item_combiner_chk #(
    parameter int N_COND = 16,
    parameter int N_ITEM = 8,
    parameter int IDX_W  = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [1:0]                       wr_sel,
    input logic [IDX_W-1:0]                 wr_idx,
    input logic [N_COND-1:0]                stage_val,
    input logic [N_COND-1:0]                stage_care,
    input logic [N_COND-1:0]                cond_q,
    input logic [N_ITEM-1:0][N_COND-1:0]    val_all,
    input logic [N_ITEM-1:0][N_COND-1:0]    care_all,
    input logic [N_ITEM-1:0]                items
);
    // R1: items are idle on the first edge after reset release.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (items == '0));

    // R6: staging writes never touch committed words.
    p_stage_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd3) |=> ($stable(val_all) && $stable(care_all)));

    for (genvar i = 0; i < N_ITEM; i++) begin : g_chk
        // R4: an empty care mask keeps the item low.
        p_empty_care_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (care_all[i] == '0) |=> !items[i]);

        // R3: any cared-for mismatch keeps the item low.
        p_mismatch_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (((cond_q ^ val_all[i]) & care_all[i]) != '0) |=> !items[i]);

        // R7: a commit to this item loads the staged pair.
        p_commit_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == 2'd3 && wr_idx == IDX_W'(i)) |=>
            (val_all[i] == $past(stage_val) && care_all[i] == $past(stage_care)));

        // R7: a commit to another item leaves this one alone.
        p_commit_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == 2'd3 && wr_idx != IDX_W'(i)) |=>
            ($stable(val_all[i]) && $stable(care_all[i])));
    end
endmodule

bind trig_item_combiner trig_item_combiner_chk #(
    .N_COND(N_COND), .N_ITEM(N_ITEM), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .stage_val(stage_val), .stage_care(stage_care), .cond_q(cond_q),
    .val_all(val_all), .care_all(care_all), .items(items)
);

// File: tb/test_trig_item_combiner.sv
`timescale 1ns/1ps
module test_trig_item_combiner;
    localparam int N_EXT  = 20;
    localparam int N_INT  = 4;
    localparam int N_COND = 16;
    localparam int N_ITEM = 8;
    localparam int LUT_IN = 4;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 16;
    localparam int N_IN   = N_EXT + N_INT;
    localparam int N_GRP  = N_IN / LUT_IN;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_EXT-1:0]  ext_in;
    logic [N_INT-1:0]  int_in;
    logic              wr_en;
    logic [1:0]        wr_sel;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [N_ITEM-1:0] items;

    int checks = 0;
    int failures = 0;

    logic [15:0]       m_lut  [N_COND];
    logic [N_COND-1:0] m_val  [N_ITEM];
    logic [N_COND-1:0] m_care [N_ITEM];
    logic [N_COND-1:0] m_sval, m_scare;

    always #2 clk = ~clk;

    trig_item_combiner i_trig_item_combiner (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .int_in(int_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .items(items)
    );

    function automatic logic [N_ITEM-1:0] model(input logic [N_IN-1:0] v);
        logic [N_COND-1:0] cond;
        logic [N_ITEM-1:0] r;
        for (int c = 0; c < N_COND; c++) begin
            cond[c] = m_lut[c][v[(c % N_GRP)*LUT_IN +: LUT_IN]];
        end
        for (int i = 0; i < N_ITEM; i++) begin
            r[i] = (m_care[i] != '0) && (((cond ^ m_val[i]) & m_care[i]) == '0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N_ITEM-1:0] exp);
        checks++;
        if (items !== exp) begin
            failures++;
            $display("FAIL %s items=%h expected=%h", req, items, exp);
        end
    endtask

    task automatic wr(input logic en, input logic [1:0] sel, input int idx,
                      input logic [DATA_W-1:0] data);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_idx = IDX_W'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_lut(input int c, input logic [15:0] t);
        wr(1'b1, 2'd0, c, t);
        m_lut[c] = t;
    endtask

    task automatic set_item(input int i, input logic [N_COND-1:0] v,
                            input logic [N_COND-1:0] c);
        wr(1'b1, 2'd1, 0, v);
        wr(1'b1, 2'd2, 0, c);
        wr(1'b1, 2'd3, i, '0);
        m_val[i] = v; m_care[i] = c;
    endtask

    // Drive n vectors back to back; compare two cycles behind (R5 pipeline).
    task automatic run(input int n, input string req);
        logic [N_ITEM-1:0] e0, e1;
        logic [N_IN-1:0] v;
        e0 = '0; e1 = '0;
        for (int t = 0; t < n + 2; t++) begin
            @(negedge clk);
            if (t >= 2) check(req, e0);
            e0 = e1;
            if (t < n) begin
                v = {$urandom, $urandom};
                {int_in, ext_in} = v;
                e1 = model(v);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd715));
        rst_n = 1'b0; ext_in = '0; int_in = '0;
        wr_en = 1'b0; wr_sel = 2'd0; wr_idx = '0; wr_data = '0;
        for (int c = 0; c < N_COND; c++) m_lut[c] = '0;
        for (int i = 0; i < N_ITEM; i++) begin m_val[i] = '0; m_care[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);
        ext_in = '1; int_in = '1;
        repeat (3) @(negedge clk);
        check("R1", '0);

        // R2: tables true only at address 15; one-hot care on items.
        for (int c = 0; c < N_COND; c++) set_lut(c, 16'h8000);
        for (int i = 0; i < N_ITEM; i++) set_item(i, N_COND'(1) << i, N_COND'(1) << i);
        @(negedge clk); ext_in = '1; int_in = '1;
        repeat (2) @(negedge clk);
        check("R2", '1);
        ext_in = '0;
        repeat (2) @(negedge clk);
        check("R2", model({int_in, ext_in}));
        for (int c = 0; c < N_COND; c++) set_lut(c, 16'($urandom));
        run(40, "R2");

        // R4: empty care mask with a full value word.
        set_item(7, '1, '0);
        run(30, "R4");
        // R5: back-to-back vectors with two-stage latency.
        run(30, "R5");

        // R6: stage a new word for item 0 without committing.
        wr(1'b1, 2'd1, 0, 16'($urandom));
        wr(1'b1, 2'd2, 0, 16'h0003);
        run(30, "R6");
        // R7: commit into item 0 only.
        wr(1'b1, 2'd3, 0, '0);
        m_val[0] = i_trig_item_combiner_stage_val_model();
        m_care[0] = 16'h0003;
        run(30, "R7");
        set_lut(3, 16'hA5C3);
        run(20, "R7");

        // R8: disabled writes and an out-of-range commit.
        wr(1'b0, 2'd0, 2, 16'hFFFF);
        wr(1'b0, 2'd1, 0, 16'hFFFF);
        wr(1'b0, 2'd3, 1, '0);
        wr(1'b1, 2'd3, 12, '0);
        run(30, "R8");

        // R9: change only uncared value bits.
        for (int i = 0; i < N_ITEM; i++)
            set_item(i, m_val[i] ^ (16'($urandom) & ~m_care[i]), m_care[i]);
        run(30, "R9");

        // R3: random configurations with sparse care masks.
        for (int r = 0; r < 15; r++) begin
            for (int c = 0; c < N_COND; c++) set_lut(c, 16'($urandom));
            for (int i = 0; i < N_ITEM; i++)
                set_item(i, 16'($urandom), 16'($urandom & $urandom & $urandom));
            run(25, "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Staged value as last written through the port, tracked by the bench.
    logic [N_COND-1:0] tb_sval = '0;
    always @(posedge clk) if (rst_n && wr_en && wr_sel == 2'd1) tb_sval <= wr_data;
    function automatic logic [N_COND-1:0] i_trig_item_combiner_stage_val_model();
        return tb_sval;
    endfunction
endmodule